// File: doc/BRIEF.md
# Double-Buffered BCD Real-Time Clock Register Bank

This block is the byte-wide register bank of a real-time clock. A private set of counters keeps time of day and calendar date in packed BCD. The host never reads these counters directly. It reads a separate bank of visible copies. Each `tick` advances the private counters. In the same clock edge, every visible time byte is reloaded at once from the advanced values. A multi-byte read therefore never sees a half-carried value.

The 64-byte map has three parts. It holds eight time and date fields. It holds six plain storage bytes: three alarm bytes placed between the time fields, a binary command byte, and two watchdog bytes. The rest of the map is free user storage. The top bit of the command byte freezes the transfer. While that bit is set, the host can read all time bytes without racing a tick, and the private counters keep running.

A host write to a time field loads the private counter and its visible copy together. Counting then continues from the written value.

Top module: `rtc_regbank`

## Requirements
- R1: After a synchronous reset, the time bytes read as follows: hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00. All other bytes read 0x00.
- R2: A read (`bus_en`=1, `bus_we`=0) returns the addressed byte on `rd_data`, with `rd_valid` high, on the cycle after it is issued. A write or an idle cycle leaves `rd_valid` low on the next cycle.
- R3: The bytes at addresses 0x0E to 0x3F are free storage. Each one reads back the last value written to it.
- R4: The alarm bytes at 0x03, 0x05 and 0x07, the command byte at 0x0B, and the watchdog bytes at 0x0C and 0x0D are plain read/write storage. Ticks never change them.
- R5: Each `tick` adds one, in BCD, to the private hundredths counter at 0x00. Without a tick or a write, the private counters hold their values.
- R6: A carry passes upward when a field rolls over: hundredths 0x99, seconds (0x01) 0x59, minutes (0x02) 0x59 and hours (0x04) 0x23 each return to 0x00 and advance the next field. An hours rollover advances both the day of week and the date.
- R7: The day of week (0x06) counts from 0x01 to 0x07 and then returns to 0x01.
- R8: The date (0x08) returns to 0x01 after the last day of the month, and the month then advances. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the binary value of the BCD year is divisible by four, and 28 days otherwise. All other months have 31 days. The month (0x09) goes from 0x12 to 0x01 and carries into the year (0x0A), which goes from 0x99 to 0x00.
- R9: On a tick, when bit 7 of the command byte is clear, all eight visible time bytes take the advanced private values in that same edge.
- R10: While bit 7 of the command byte is set, ticks leave the visible time bytes unchanged, and the private counters keep counting. On the first tick after the bit is cleared, all accumulated time appears in the visible bytes.
- R11: A host write to a time field loads both the private and the visible copy. The byte reads back at once, and later ticks count from the written value.
- R12: When a write to a time field and a tick fall in the same cycle, the written field takes the written value. The other fields advance as the tick requires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle pulse that advances time by one hundredth of a second |
| bus_en | input | 1 | Host access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Read data |

## Verification
Counting is tried from preset times that sit one tick before a boundary. These are: an ordinary day end, February's end in a leap year, in a non-leap year and in year 00, the end of a 30-day month, and the end of the year. Each case separates a different month-length or carry path. Tick runs with the freeze bit set and then cleared show whether the visible bytes follow the private counters or hold still. The reads taken right after clearing the bit, but before any tick, show that a refresh happens only at the transfer. Writes that land on a tick, and plain or user writes followed by ticks, show write priority and the independence of storage bytes from counting.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;

    localparam int ADDR_W     = 6;
    localparam int NUM_FIELDS = 8;
    localparam int NUM_PLAIN  = 6;
    localparam int FN_COUNT   = 14;

    typedef logic [7:0] bcd_t;
    typedef bcd_t [NUM_FIELDS-1:0] time_vec_t;

    typedef enum logic [2:0] {
        F_HUND = 3'd0,
        F_SEC  = 3'd1,
        F_MIN  = 3'd2,
        F_HOUR = 3'd3,
        F_DOW  = 3'd4,
        F_DATE = 3'd5,
        F_MON  = 3'd6,
        F_YEAR = 3'd7
    } field_e;

    localparam logic [2:0] PL_CMD = 3'd3;

    typedef enum logic [1:0] {
        K_TIME  = 2'd0,
        K_PLAIN = 2'd1,
        K_USER  = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [2:0] idx;
    } decode_t;

    typedef struct packed {
        logic wrap;
        bcd_t val;
    } step_t;

    localparam time_vec_t RESET_TIME =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t d;
        d.kind = K_TIME;
        d.idx  = 3'd0;
        case (a)
            6'h00: d.idx = F_HUND;
            6'h01: d.idx = F_SEC;
            6'h02: d.idx = F_MIN;
            6'h04: d.idx = F_HOUR;
            6'h06: d.idx = F_DOW;
            6'h08: d.idx = F_DATE;
            6'h09: d.idx = F_MON;
            6'h0A: d.idx = F_YEAR;
            6'h03: begin d.kind = K_PLAIN; d.idx = 3'd0; end
            6'h05: begin d.kind = K_PLAIN; d.idx = 3'd1; end
            6'h07: begin d.kind = K_PLAIN; d.idx = 3'd2; end
            6'h0B: begin d.kind = K_PLAIN; d.idx = PL_CMD; end
            6'h0C: begin d.kind = K_PLAIN; d.idx = 3'd4; end
            6'h0D: begin d.kind = K_PLAIN; d.idx = 3'd5; end
            default: d.kind = K_USER;
        endcase
        return d;
    endfunction

    function automatic logic is_leap(input bcd_t yr);
        logic [6:0] bin;
        bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic bcd_t month_len(input bcd_t mon, input bcd_t yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic bcd_t field_lo(input field_e f);
        return (f == F_DOW || f == F_DATE || f == F_MON) ? 8'h01 : 8'h00;
    endfunction

    function automatic bcd_t field_hi(input field_e f, input bcd_t mlen);
        case (f)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_DOW:        return 8'h07;
            F_DATE:       return mlen;
            F_MON:        return 8'h12;
            default:      return 8'h99;
        endcase
    endfunction

    function automatic field_e carry_src(input field_e f);
        case (f)
            F_SEC:        return F_HUND;
            F_MIN:        return F_SEC;
            F_HOUR:       return F_MIN;
            F_DOW, F_DATE: return F_HOUR;
            F_MON:        return F_DATE;
            F_YEAR:       return F_MON;
            default:      return F_HUND;
        endcase
    endfunction

    function automatic step_t bcd_step(input bcd_t v, input bcd_t lo, input bcd_t hi);
        step_t s;
        if (v >= hi) begin
            s.wrap = 1'b1;
            s.val  = lo;
        end else if (v[3:0] >= 4'd9) begin
            s.wrap = 1'b0;
            s.val  = {v[7:4] + 4'd1, 4'd0};
        end else begin
            s.wrap = 1'b0;
            s.val  = v + 8'd1;
        end
        return s;
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_regbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      wr_en,
    input  field_e    wr_field,
    input  bcd_t      wr_data,
    output time_vec_t cur,
    output time_vec_t nxt
);

    time_vec_t             adv;
    logic [NUM_FIELDS-1:0] carry;
    logic [NUM_FIELDS-1:0] wrap;
    bcd_t                  mlen;
    step_t                 st;

    always_comb begin
        mlen  = month_len(cur[F_MON], cur[F_YEAR]);
        adv   = cur;
        carry = '0;
        wrap  = '0;
        st    = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            if (f == 0) carry[f] = tick;
            else        carry[f] = wrap[carry_src(field_e'(f))];
            st = bcd_step(cur[f], field_lo(field_e'(f)), field_hi(field_e'(f), mlen));
            if (carry[f]) begin
                adv[f]  = st.val;
                wrap[f] = st.wrap;
            end
        end
        nxt = adv;
        if (wr_en) nxt[wr_field] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= RESET_TIME;
        else     cur <= nxt;
    end

endmodule

// File: rtl/rtc_visible_bank.sv
module rtc_visible_bank
    import rtc_regbank_pkg::*;
#(
    parameter int FREEZE_BIT = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  time_vec_t              int_next,
    input  logic                   wr_time,
    input  logic                   wr_plain,
    input  logic [2:0]             idx,
    input  bcd_t                   wdata,
    output time_vec_t              vis_time,
    output bcd_t [NUM_PLAIN-1:0]   plain_q,
    output logic                   freeze
);

    assign freeze = plain_q[PL_CMD][FREEZE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_time <= RESET_TIME;
        end else if (tick && !freeze) begin
            vis_time <= int_next;
        end else if (wr_time) begin
            vis_time[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           plain_q <= '0;
        else if (wr_plain) plain_q[idx] <= wdata;
    end

endmodule

// File: rtl/rtc_user_ram.sv
module rtc_user_ram #(
    parameter int AW    = 6,
    parameter int BASE  = 14,
    parameter int DEPTH = 50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam logic [AW-1:0] BASE_L  = AW'(BASE);
    localparam logic [AW-1:0] DEPTH_L = AW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] off;
    logic          in_range;

    assign off      = addr - BASE_L;
    assign in_range = (addr >= BASE_L) && (off < DEPTH_L);
    assign rdata    = in_range ? mem[off] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we && in_range) begin
            mem[off] <= wdata;
        end
    end

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_regbank_pkg::*;
#(
    parameter int FREEZE_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);

    localparam int USER_DEPTH = (1 << ADDR_W) - FN_COUNT;

    decode_t              dec;
    logic                 wr_time;
    logic                 wr_plain;
    logic                 wr_user;
    time_vec_t            int_time;
    time_vec_t            int_next;
    time_vec_t            vis_time;
    bcd_t [NUM_PLAIN-1:0] plain_q;
    logic                 freeze;
    bcd_t                 user_rd;
    bcd_t                 rd_mux;

    assign dec      = decode_addr(bus_addr);
    assign wr_time  = bus_en && bus_we && (dec.kind == K_TIME);
    assign wr_plain = bus_en && bus_we && (dec.kind == K_PLAIN);
    assign wr_user  = bus_en && bus_we && (dec.kind == K_USER);

    rtc_time_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_en    (wr_time),
        .wr_field (field_e'(dec.idx)),
        .wr_data  (bus_wdata),
        .cur      (int_time),
        .nxt      (int_next)
    );

    rtc_visible_bank #(.FREEZE_BIT(FREEZE_BIT)) u_vis (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .int_next (int_next),
        .wr_time  (wr_time),
        .wr_plain (wr_plain),
        .idx      (dec.idx),
        .wdata    (bus_wdata),
        .vis_time (vis_time),
        .plain_q  (plain_q),
        .freeze   (freeze)
    );

    rtc_user_ram #(.AW(ADDR_W), .BASE(FN_COUNT), .DEPTH(USER_DEPTH)) u_user (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_user),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (user_rd)
    );

    always_comb begin
        case (dec.kind)
            K_TIME:  rd_mux = vis_time[dec.idx];
            K_PLAIN: rd_mux = plain_q[dec.idx];
            default: rd_mux = user_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= bus_en && !bus_we;
            if (bus_en && !bus_we) rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
    import rtc_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input time_vec_t         int_time,
    input time_vec_t         vis_time,
    input logic              freeze
);

    // R2
    p_read_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we) |=> rd_valid);

    // R2
    p_write_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && !bus_we) |=> !rd_valid);

    // R3
    p_user_readback_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_we && bus_addr >= 6'h0E) ##1
        (bus_en && !bus_we && bus_addr == $past(bus_addr))
        |=> rd_data == $past(bus_wdata, 2));

    // R5
    p_hund_moves_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !(bus_en && bus_we && bus_addr == 6'h00))
        |=> int_time[0] != $past(int_time[0]));

    // R5
    p_counters_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(bus_en && bus_we)) |=> $stable(int_time));

    // R9
    p_transfer_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze) |=> vis_time == int_time);

    // R10
    p_frozen_view_r10: assert property (@(posedge clk) disable iff (rst)
        (freeze && !(bus_en && bus_we)) |=> $stable(vis_time));

endmodule

bind rtc_regbank rtc_regbank_chk u_chk (.*);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       bus_en;
    logic       bus_we;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata;
    logic       rd_valid;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    rtc_regbank uut (
        .clk(clk), .rst(rst), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // monitor: pops scoreboard on each returned read
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: rd_valid got 1 expected 0");
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic write_tick(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = 1; bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        tick = 0; bus_en = 0; bus_we = 0;
    endtask

    task automatic set_time(input logic [7:0] h, s, m, hr, dw, dt, mo, yr);
        bus_write(6'h00, h);  bus_write(6'h01, s);  bus_write(6'h02, m);
        bus_write(6'h04, hr); bus_write(6'h06, dw); bus_write(6'h08, dt);
        bus_write(6'h09, mo); bus_write(6'h0A, yr);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1; tick = 0; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_read(6'h00, 8'h00, "R1 hund");
        bus_read(6'h01, 8'h00, "R1 sec");
        bus_read(6'h04, 8'h00, "R1 hour");
        bus_read(6'h06, 8'h01, "R1 dow");
        bus_read(6'h08, 8'h01, "R1 date");
        bus_read(6'h09, 8'h01, "R1 month");
        bus_read(6'h0A, 8'h00, "R1 year");
        bus_read(6'h03, 8'h00, "R1 alarm");
        bus_read(6'h0B, 8'h00, "R1 cmd");
        bus_read(6'h3F, 8'h00, "R1 user");

        // R3 user bytes; R2 no valid after a write
        bus_write(6'h0E, 8'hA5);
        n_checks++;
        if (rd_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: rd_valid after write got %b expected 0", rd_valid);
        end
        bus_write(6'h3F, 8'h3C);
        bus_write(6'h20, 8'h7E);
        bus_read(6'h0E, 8'hA5, "R3 user 0E");
        bus_read(6'h3F, 8'h3C, "R3 user 3F");
        bus_read(6'h20, 8'h7E, "R3 user 20");

        // R4 plain bytes unaffected by ticks
        bus_write(6'h03, 8'h12); bus_write(6'h05, 8'h34); bus_write(6'h07, 8'h56);
        bus_write(6'h0B, 8'h05); bus_write(6'h0C, 8'h78); bus_write(6'h0D, 8'h90);
        do_tick(); do_tick(); do_tick();
        bus_read(6'h03, 8'h12, "R4 alarm0");
        bus_read(6'h05, 8'h34, "R4 alarm1");
        bus_read(6'h07, 8'h56, "R4 alarm2");
        bus_read(6'h0B, 8'h05, "R4 cmd");
        bus_read(6'h0C, 8'h78, "R4 wd0");
        bus_read(6'h0D, 8'h90, "R4 wd1");
        bus_read(6'h0E, 8'hA5, "R4 user after ticks");
        // R5 / R9 three ticks seen in the visible copy
        bus_read(6'h00, 8'h03, "R5 R9 hund after 3 ticks");

        // R6 R7 R8 end of a non-leap February
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        do_tick();
        bus_read(6'h00, 8'h00, "R6 hund");
        bus_read(6'h01, 8'h00, "R6 sec");
        bus_read(6'h02, 8'h00, "R6 min");
        bus_read(6'h04, 8'h00, "R6 hour");
        bus_read(6'h06, 8'h01, "R7 dow wrap");
        bus_read(6'h08, 8'h01, "R8 date nonleap");
        bus_read(6'h09, 8'h03, "R8 month nonleap");
        bus_read(6'h0A, 8'h23, "R8 year kept");

        // R8 leap February 24
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        do_tick();
        bus_read(6'h08, 8'h29, "R8 leap date 29");
        bus_read(6'h09, 8'h02, "R8 leap month");
        bus_read(6'h06, 8'h03, "R7 dow step");
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        do_tick();
        bus_read(6'h08, 8'h01, "R8 leap end date");
        bus_read(6'h09, 8'h03, "R8 leap end month");

        // R8 year 00 is leap
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        do_tick();
        bus_read(6'h08, 8'h29, "R8 year00 leap");

        // R8 30-day month
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
        do_tick();
        bus_read(6'h08, 8'h01, "R8 april end date");
        bus_read(6'h09, 8'h05, "R8 april end month");

        // R8 year end
        set_time(8'h99, 8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        do_tick();
        bus_read(6'h08, 8'h01, "R8 yearend date");
        bus_read(6'h09, 8'h01, "R8 yearend month");
        bus_read(6'h0A, 8'h00, "R8 yearend year");

        // R6 BCD digit carry inside a field
        set_time(8'h09, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        do_tick();
        bus_read(6'h00, 8'h10, "R5 digit carry");

        // R10 freeze
        set_time(8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        bus_write(6'h0B, 8'h80);
        repeat (5) do_tick();
        bus_read(6'h00, 8'h10, "R10 frozen view");
        bus_read(6'h0B, 8'h80, "R10 cmd readback");
        bus_write(6'h0B, 8'h00);
        bus_read(6'h00, 8'h10, "R10 no refresh before tick");
        do_tick();
        bus_read(6'h00, 8'h16, "R10 catch up");

        // R11 write loads both copies
        set_time(8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        bus_write(6'h01, 8'h42);
        bus_read(6'h01, 8'h42, "R11 immediate");
        do_tick();
        bus_read(6'h01, 8'h42, "R11 sec kept");
        bus_read(6'h00, 8'h01, "R11 hund counted");
        bus_write(6'h00, 8'h37);
        do_tick();
        bus_read(6'h00, 8'h38, "R11 count from written");

        // R12 write and tick together
        set_time(8'h50, 8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        write_tick(6'h01, 8'h33);
        bus_read(6'h00, 8'h51, "R12 other field advances");
        bus_read(6'h01, 8'h33, "R12 written field wins");
        write_tick(6'h00, 8'h70);
        bus_read(6'h00, 8'h70, "R12 written hund wins");
        bus_read(6'h01, 8'h33, "R12 sec unchanged");

        drain();
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2: pending reads got %0d expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule